// File: doc/BRIEF.md
# Two-operation memory-to-memory processor

A tiny 16-bit processor core whose whole instruction set is addition, bitwise NOR and one conditional jump. It has no accumulator and no register file. Both operands of an arithmetic instruction live in memory, and the result overwrites the second operand. One single-port synchronous memory holds the program and the data. The core reaches it through a single address, write-data, write-enable and read-data path. Inside the core there is one temporary operand register, one destination address register, the program counter and a carry flag.

Every instruction runs through the same eight-cycle sequence. The core fetches the first word, then the second word, reads the source, reads the destination, computes, stores, idles one cycle, and advances the program counter. A jump uses only the first of these slots. There is no stack and no indirect addressing. A program builds pointers by adding to the address field of one of its own instruction words held in RAM. It builds shifts from additions: a value added to itself shifts left, and a conditional jump on the carry can then insert the bit that was shifted out.

Top module: `mmcpu_top`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the core presents address 0 with write enable low. After reset the program counter is 0 and the carry flag is clear, so a jump at address 0 is taken.
- R2: A word with bit 15 set is a jump that occupies one word. Its bits 14..0 are the target. When the jump is not taken, the next instruction is fetched from the jump's own address plus 1.
- R3: A word with bit 15 clear starts a two-word instruction. In that word, bit 14 set selects NOR and clear selects add. Bit 13 set makes bits 12..0 an immediate value, zero-extended to 16 bits. Bit 13 clear makes bits 12..0 the source address. Bits 14..0 of the second word give the destination address, and the next instruction follows at the first word's address plus 2.
- R4: Add writes (source + destination) mod 2^16 to the destination and loads the carry flag with the carry out of bit 15.
- R5: NOR writes the bitwise NOR of the source and the destination to the destination and leaves the carry flag unchanged.
- R6: A jump is taken when the carry flag is clear and falls through when it is set. A jump never changes the carry flag.
- R7: Every instruction takes exactly 8 clock cycles. Counting from the cycle in which an instruction's address is first presented, the next instruction's address appears 8 cycles later.
- R8: An add or NOR makes exactly one memory write, in the sixth cycle of its sequence, to its destination address. A jump makes no write.
- R9: Instruction words are read from memory each time they execute. A store into an instruction word therefore changes what that instruction does the next time it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 15 | Registered word address to the memory |
| mem_wdata | output | 16 | Registered write data |
| mem_we | output | 1 | Registered write enable, high for one cycle per store |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |

## Verification
An internal fault can only show up as a wrong memory address, a misplaced write or a wrong stored word. A corrupt carry flag changes which path the next conditional jump takes, and the fetch address at the end of that jump's eight cycles is then wrong. A sequencing or program-counter fault shifts the fetch address or the single write pulse out of its fixed slot within one instruction. A datapath fault appears as a wrong word written to the destination during the sixth cycle of the instruction that caused it. Rotate programs with and without a carry out, a NOR that must keep the carry, the widest immediate, and a program that patches its own source field each force one of these effects within a few instructions.

// File: rtl/mmcpu_pkg.sv
package mmcpu_pkg;
  localparam int PH_W = 3;

  typedef enum logic [PH_W-1:0] {
    PH_FETCH0 = 3'd0,
    PH_FETCH1 = 3'd1,
    PH_SRC    = 3'd2,
    PH_DST    = 3'd3,
    PH_EXEC   = 3'd4,
    PH_STORE  = 3'd5,
    PH_IDLE   = 3'd6,
    PH_NEXT   = 3'd7
  } phase_e;
endpackage

// File: rtl/mmcpu_phase.sv
module mmcpu_phase
  import mmcpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);
  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + PH_W'(1);
  end

  assign phase = phase_e'(cnt_q);
endmodule

// File: rtl/mmcpu_alu.sv
module mmcpu_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sel_nor,
  output logic [DATA_W-1:0] y,
  output logic              cout
);
  logic [DATA_W:0] sum;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b};
    cout = sum[DATA_W];
    if (sel_nor) y = ~(a | b);
    else         y = sum[DATA_W-1:0];
  end
endmodule

// File: rtl/mmcpu_pc.sv
module mmcpu_pc #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              is_jump,
  input  logic              carry,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pc_next
);
  always_comb begin
    if (is_jump) pc_next = carry ? pc + ADDR_W'(1) : target;
    else         pc_next = pc + ADDR_W'(2);
  end

  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (advance) pc <= pc_next;
  end

  // R6
  jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && is_jump && !carry) |=> (pc == $past(target)));

  // R2
  jump_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && is_jump && carry) |=> (pc == $past(pc) + ADDR_W'(1)));
endmodule

// File: rtl/mmcpu_top.sv
module mmcpu_top
  import mmcpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int JMP_B = DATA_W - 1;
  localparam int NOR_B = DATA_W - 2;
  localparam int IMM_B = DATA_W - 3;
  localparam int SRC_W = DATA_W - 3;

  phase_e            phase;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] tmp;
  logic [ADDR_W-1:0] ar;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] pc_next;
  logic              carry;
  logic [DATA_W-1:0] alu_y;
  logic              alu_cout;
  logic [ADDR_W-1:0] src_addr;
  logic [DATA_W-1:0] imm_val;

  assign src_addr = {{(ADDR_W-SRC_W){1'b0}}, mem_rdata[SRC_W-1:0]};
  assign imm_val  = {{(DATA_W-SRC_W){1'b0}}, ir[SRC_W-1:0]};

  mmcpu_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  mmcpu_alu #(.DATA_W(DATA_W)) u_alu (
    .a       (tmp),
    .b       (mem_rdata),
    .sel_nor (ir[NOR_B]),
    .y       (alu_y),
    .cout    (alu_cout)
  );

  mmcpu_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .advance (phase == PH_NEXT),
    .is_jump (ir[JMP_B]),
    .carry   (carry),
    .target  (ir[ADDR_W-1:0]),
    .pc      (pc),
    .pc_next (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir        <= '0;
      ar        <= '0;
      tmp       <= '0;
      carry     <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH0: mem_addr <= pc + ADDR_W'(1);
        PH_FETCH1: begin
          ir       <= mem_rdata;
          mem_addr <= src_addr;
        end
        PH_SRC: begin
          ar       <= mem_rdata[ADDR_W-1:0];
          mem_addr <= mem_rdata[ADDR_W-1:0];
        end
        PH_DST: tmp <= ir[IMM_B] ? imm_val : mem_rdata;
        PH_EXEC: begin
          if (!ir[JMP_B]) begin
            tmp       <= alu_y;
            mem_wdata <= alu_y;
            mem_we    <= 1'b1;
            if (!ir[NOR_B]) carry <= alu_cout;
          end
        end
        PH_STORE: mem_we <= 1'b0;
        PH_NEXT:  mem_addr <= pc_next;
        default:  ;
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_addr == '0 && !mem_we && !carry && pc == '0));

  // R7
  fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH0) |-> (mem_addr == pc));

  // R8
  store_slot_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (phase == PH_STORE && mem_addr == ar && !ir[JMP_B]));

  // R5
  nor_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && ir[NOR_B] && !ir[JMP_B]) |=> $stable(carry));
endmodule

// File: tb/mmcpu_top_tb_top.sv
`timescale 1ns/1ps
module mmcpu_top_tb_top;
  localparam int DW = 16;
  localparam int AW = 15;
  localparam int MW = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] mem [MW];
  logic          ld_en = 1'b0;
  logic [7:0]    ld_a  = '0;
  logic [DW-1:0] ld_d  = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mmcpu_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata)
  );

  always @(posedge clk) begin
    if (ld_en)       mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  // encodings: bit15 jump, bit14 NOR, bit13 immediate, bits 12..0 field
  function automatic logic [15:0] e_add(input int s);  return 16'h0000 | 16'(s); endfunction
  function automatic logic [15:0] e_addi(input int v); return 16'h2000 | 16'(v); endfunction
  function automatic logic [15:0] e_nor(input int s);  return 16'h4000 | 16'(s); endfunction
  function automatic logic [15:0] e_nori(input int v); return 16'h6000 | 16'(v); endfunction
  function automatic logic [15:0] e_jmp(input int t);  return 16'h8000 | 16'(t); endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    ld_en = 1'b1; ld_a = 8'(a); ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic begin_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < MW; i++) poke(i, 16'h0000);
  endtask

  task automatic end_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // vectors: {x rotated left, y nor source, z nor destination, w immediate-nor destination}
  localparam logic [63:0] VEC [5] = '{
    {16'h8000, 16'h00FF, 16'hF000, 16'h0000},
    {16'h1234, 16'h0F0F, 16'h00F0, 16'hF0F0},
    {16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF},
    {16'h0000, 16'hAAAA, 16'h5555, 16'h1234},
    {16'h7FFF, 16'h8001, 16'h0100, 16'h00F0}
  };

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    int wcount;
    logic [15:0] x, y, z, w;

    // R1: reset state
    begin_reset();
    chk("R1 reset we", {15'd0, mem_we}, 16'h0000);
    chk("R1 reset addr", {1'b0, mem_addr}, 16'h0000);

    // table walk: rotate left, nor from memory, nor with immediate
    for (int v = 0; v < 5; v++) begin
      {x, y, z, w} = VEC[v];
      begin_reset();
      poke(0, e_add(100));  poke(1, 16'd100);
      poke(2, e_jmp(5));
      poke(3, e_addi(1));   poke(4, 16'd100);
      poke(5, e_nor(101));  poke(6, 16'd102);
      poke(7, e_nori(16'h0F0F)); poke(8, 16'd103);
      poke(9, e_jmp(9));
      poke(100, x); poke(101, y); poke(102, z); poke(103, w);
      end_reset();
      chk("R1 first fetch", {1'b0, mem_addr}, 16'h0000);
      wait_cyc(5);
      chk("R8 store slot we", {15'd0, mem_we}, 16'h0001);
      chk("R8 store slot addr", {1'b0, mem_addr}, 16'd100);
      wait_cyc(1);
      chk("R8 single write", {15'd0, mem_we}, 16'h0000);
      wait_cyc(2);
      chk("R7 next fetch", {1'b0, mem_addr}, 16'd2);
      wait_cyc(80);
      chk("R4 R6 rotate left", mem[100], {x[14:0], x[15]});
      chk("R5 nor memory", mem[102], ~(y | z));
      chk("R3 nor immediate", mem[103], ~(16'h0F0F | w));
    end

    // R5 NOR keeps carry set; R6 falls through on carry
    begin_reset();
    poke(0, e_addi(1));  poke(1, 16'd100);
    poke(2, e_nori(0));  poke(3, 16'd101);
    poke(4, e_jmp(7));
    poke(5, e_addi(5));  poke(6, 16'd102);
    poke(7, e_jmp(7));
    poke(100, 16'hFFFF); poke(101, 16'h1234); poke(102, 16'h0003);
    end_reset();
    wait_cyc(80);
    chk("R4 add wrap", mem[100], 16'h0000);
    chk("R5 nor result", mem[101], 16'hEDCB);
    chk("R5 R6 carry kept so fall through", mem[102], 16'h0008);

    // R3 widest immediate, R4 carry out
    begin_reset();
    poke(0, e_addi(16'h1FFF)); poke(1, 16'd100);
    poke(2, e_jmp(5));
    poke(3, e_addi(2));        poke(4, 16'd101);
    poke(5, e_jmp(5));
    poke(100, 16'hE001);
    end_reset();
    wait_cyc(64);
    chk("R3 imm 13 bit", mem[100], 16'h0000);
    chk("R4 carry out", mem[101], 16'h0002);

    // R9 self-modifying source field
    begin_reset();
    poke(0, e_add(110)); poke(1, 16'd2);
    poke(2, e_add(104)); poke(3, 16'd120);
    poke(4, e_jmp(4));
    poke(110, 16'h0002); poke(104, 16'h0005); poke(106, 16'h0100); poke(120, 16'h0010);
    end_reset();
    wait_cyc(48);
    chk("R9 patched word", mem[2], 16'h006A);
    chk("R9 patched operand", mem[120], 16'h0110);

    // R1 reset mid-run clears carry; R2 R8 jump writes nothing
    begin_reset();
    poke(0, e_addi(1)); poke(1, 16'd100);
    for (int i = 2; i < 40; i++) poke(i, e_jmp(2));
    poke(100, 16'hFFFF);
    end_reset();
    wait_cyc(16);
    begin_reset();
    poke(0, e_jmp(20)); poke(20, e_jmp(20));
    end_reset();
    wcount = 0;
    for (int c = 0; c < 8; c++) begin
      if (mem_we) wcount++;
      wait_cyc(1);
    end
    chk("R1 R6 jump taken after reset", {1'b0, mem_addr}, 16'd20);
    for (int c = 0; c < 16; c++) begin
      if (mem_we) wcount++;
      wait_cyc(1);
    end
    chk("R8 jump no write", 16'(wcount), 16'h0000);
    chk("R2 jump loop", {1'b0, mem_addr}, 16'd20);

    report();
  end
endmodule